// File: doc/BRIEF.md
# Stall-Triggered Instruction Queue Squash

This block is an in-order instruction queue. It also reduces how long valid instructions stay in storage that a particle strike could corrupt. Entries enter through an enqueue port and leave, oldest first, through an issue port. Each entry has a valid flag, a sequence number and a payload.

A cache miss can be flagged as one expected to take a long time. When that happens, the controller invalidates every waiting entry except the oldest one. The oldest entry stays so the instruction that needs the miss data can still be serviced. The controller keeps the sequence number of the oldest discarded instruction and then refuses new entries, so the freed slots stay empty for the whole stall. When the miss completes, it sends the front end a single-cycle refetch request carrying that sequence number.

A miss flagged as short does not squash anything. A second long miss that arrives while a squash is pending is merged into the pending one. Because invalid slots are never read except for their valid flag, a fault in their other bits during the stall cannot become an error. Less throughput is the price for that protection.

Top module: `iq_squash_ctrl`

## Requirements
- R1: After reset the queue is empty: occ_count is 0, iss_valid is 0, refetch_valid is 0 and enq_ready is 1.
- R2: Entries issue strictly in the order they were accepted, with their sequence number and payload unchanged. An entry is accepted when enq_valid and enq_ready are both 1 at a clock edge. iss_valid is 1 exactly when the queue holds a valid entry, except as stated in R9.
- R3: When DEPTH valid entries are held, enq_ready is 0.
- R4: A trigger occurs in a cycle where miss_start and miss_long are both 1 and no squash is pending. One cycle after a trigger, occ_count is the smaller of 1 and the previous occupancy, and the previously oldest entry is the one presented at the issue port.
- R5: miss_start with miss_long at 0 has no effect on the queue contents, on issue, on enqueue or on refetch.
- R6: enq_ready is 0 in the trigger cycle and in every cycle until the clock edge that samples miss_done. It returns to its normal value in the cycle after that edge.
- R7: miss_done while a squash is pending raises refetch_valid for exactly one cycle, in the following cycle. refetch_seq then equals the sequence number of the second-oldest entry at the trigger. No refetch is raised if the trigger left nothing to discard. miss_done while no squash is pending is ignored.
- R8: miss_start while a squash is pending is ignored: the pending squash keeps its recorded sequence number, and only one refetch follows.
- R9: iss_valid is 0 in a trigger cycle, so nothing issues in that cycle.
- R10: occ_count always equals the number of entries whose valid flag is set, and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Offered entry is present |
| enq_seq | input | SEQ_W | Sequence number of offered entry |
| enq_data | input | DATA_W | Payload of offered entry |
| enq_ready | output | 1 | Queue accepts an entry this cycle |
| iss_valid | output | 1 | Oldest entry is available to issue |
| iss_seq | output | SEQ_W | Sequence number of oldest entry |
| iss_data | output | DATA_W | Payload of oldest entry |
| iss_ready | input | 1 | Consumer takes the oldest entry |
| miss_start | input | 1 | A cache miss has begun |
| miss_long | input | 1 | The starting miss is predicted to be long |
| miss_done | input | 1 | The outstanding miss has resolved |
| refetch_valid | output | 1 | One-cycle request to refetch |
| refetch_seq | output | SEQ_W | Sequence number to restart fetch from |
| occ_count | output | $clog2(DEPTH+1) | Number of valid entries held |

## Verification
Enqueue acceptance, issue and the trigger all act at the clock edge that samples them. Their effect on occ_count and the issue port appears in the next cycle. enq_ready and iss_valid react within the same cycle to miss_start and miss_long. refetch_valid appears one cycle after the edge that samples miss_done. The bench drives inputs just after each rising edge and compares every output at the falling edge against a scoreboard queue. Its model advances once per edge in the same order, so each result is compared in exactly the cycle it is due.

// File: rtl/iq_pkg.sv
package iq_pkg;
    parameter int SEQ_W  = 8;
    parameter int DATA_W = 16;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [DATA_W-1:0] data;
    } iq_entry_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } stall_state_e;

    // number of set bits in a flag vector of up to 64 bits
    function automatic int unsigned ones_in(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) n += int'(v[i]);
        return n;
    endfunction
endpackage

// File: rtl/iq_store.sv
module iq_store
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  iq_entry_t        push_ent,
    input  logic             pop,
    input  logic             squash,
    output iq_entry_t        head_ent,
    output logic             head_vld,
    output logic [SEQ_W-1:0] second_seq,
    output logic [CNT_W-1:0] entry_cnt,
    output logic [DEPTH-1:0] vld_vec
);
    iq_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] head, tail;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[tail] <= push_ent;
    end

    // per-slot valid flag; payload of a cleared slot is left untouched
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                vld_vec[i] <= 1'b0;
            else if (squash) begin
                if (head != PTR_W'(i)) vld_vec[i] <= 1'b0;
            end else if (push && tail == PTR_W'(i))
                vld_vec[i] <= 1'b1;
            else if (pop && head == PTR_W'(i))
                vld_vec[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else if (squash) begin
            tail <= (cnt != '0) ? bump(head) : head;
            cnt  <= (cnt != '0) ? CNT_W'(1) : '0;
        end else begin
            if (push) tail <= bump(tail);
            if (pop)  head <= bump(head);
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_ent   = mem[head];
    assign head_vld   = vld_vec[head];
    assign second_seq = mem[bump(head)].seq;
    assign entry_cnt  = cnt;
endmodule

// File: rtl/iq_stall_ctl.sv
module iq_stall_ctl
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_start,
    input  logic             miss_long,
    input  logic             miss_done,
    input  logic [CNT_W-1:0] entry_cnt,
    input  logic [SEQ_W-1:0] second_seq,
    output logic             trigger,
    output logic             pending,
    output logic             refetch_valid,
    output logic [SEQ_W-1:0] refetch_seq
);
    stall_state_e     state;
    logic             lost_any;
    logic [SEQ_W-1:0] restart_seq;

    assign pending = (state == ST_HOLD);
    assign trigger = (state == ST_RUN) && miss_start && miss_long;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_RUN;
            lost_any      <= 1'b0;
            restart_seq   <= '0;
            refetch_valid <= 1'b0;
        end else begin
            refetch_valid <= 1'b0;
            case (state)
                ST_RUN: if (trigger) begin
                    state       <= ST_HOLD;
                    lost_any    <= (entry_cnt >= CNT_W'(2));
                    restart_seq <= second_seq;
                end
                ST_HOLD: if (miss_done) begin
                    state         <= ST_RUN;
                    refetch_valid <= lost_any;
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign refetch_seq = restart_seq;
endmodule

// File: rtl/iq_occ.sv
module iq_occ
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] vld_vec,
    output logic [CNT_W-1:0] occ_count
);
    logic [63:0] wide;
    assign wide      = 64'(vld_vec);
    assign occ_count = CNT_W'(ones_in(wide));
endmodule

// File: rtl/iq_squash_ctrl.sv
module iq_squash_ctrl
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    input  logic [SEQ_W-1:0]  enq_seq,
    input  logic [DATA_W-1:0] enq_data,
    output logic              enq_ready,
    output logic              iss_valid,
    output logic [SEQ_W-1:0]  iss_seq,
    output logic [DATA_W-1:0] iss_data,
    input  logic              iss_ready,
    input  logic              miss_start,
    input  logic              miss_long,
    input  logic              miss_done,
    output logic              refetch_valid,
    output logic [SEQ_W-1:0]  refetch_seq,
    output logic [CNT_W-1:0]  occ_count
);
    iq_entry_t        in_ent, head_ent;
    logic             head_vld, push, pop, trigger, pending;
    logic [SEQ_W-1:0] second_seq;
    logic [CNT_W-1:0] entry_cnt;
    logic [DEPTH-1:0] vld_vec;

    assign in_ent.seq  = enq_seq;
    assign in_ent.data = enq_data;

    assign enq_ready = !pending && !trigger && (entry_cnt < CNT_W'(DEPTH));
    assign push      = enq_valid && enq_ready;
    assign iss_valid = head_vld && !trigger;
    assign pop       = iss_valid && iss_ready;
    assign iss_seq   = head_ent.seq;
    assign iss_data  = head_ent.data;

    iq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push(push), .push_ent(in_ent), .pop(pop),
        .squash(trigger), .head_ent(head_ent), .head_vld(head_vld),
        .second_seq(second_seq), .entry_cnt(entry_cnt), .vld_vec(vld_vec)
    );

    iq_stall_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk(clk), .rst(rst), .miss_start(miss_start), .miss_long(miss_long),
        .miss_done(miss_done), .entry_cnt(entry_cnt), .second_seq(second_seq),
        .trigger(trigger), .pending(pending), .refetch_valid(refetch_valid),
        .refetch_seq(refetch_seq)
    );

    iq_occ #(.DEPTH(DEPTH)) u_occ (
        .vld_vec(vld_vec), .occ_count(occ_count)
    );
endmodule

// File: rtl/iq_squash_checker.sv
module iq_squash_checker #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] occ_count,
    input logic [CNT_W-1:0] entry_cnt,
    input logic             trigger,
    input logic             pending,
    input logic             enq_ready,
    input logic             iss_valid,
    input logic             miss_done,
    input logic             refetch_valid
);
    AST_COUNT_AGREES: assert property (@(posedge clk) disable iff (rst)
        entry_cnt == occ_count && occ_count <= CNT_W'(DEPTH));          // R10
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        occ_count == CNT_W'(DEPTH) |-> !enq_ready);                     // R3
    AST_EMPTY_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        occ_count == '0 |-> !iss_valid);                                // R2
    AST_SQUASH_TRIM: assert property (@(posedge clk) disable iff (rst)
        trigger |=> occ_count <= CNT_W'(1));                            // R4
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        pending |-> !enq_ready);                                        // R6
    AST_REFETCH_PULSE: assert property (@(posedge clk) disable iff (rst)
        refetch_valid |=> !refetch_valid);                              // R7
    AST_REFETCH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        refetch_valid |-> $past(miss_done) && !pending);                // R7
    AST_MERGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        pending && !miss_done |=> pending && !refetch_valid);           // R8
endmodule

bind iq_squash_ctrl iq_squash_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .occ_count(occ_count), .entry_cnt(entry_cnt),
    .trigger(trigger), .pending(pending), .enq_ready(enq_ready),
    .iss_valid(iss_valid), .miss_done(miss_done), .refetch_valid(refetch_valid)
);

// File: tb/tb_iq_squash_ctrl.sv
module tb_iq_squash_ctrl;
    import iq_pkg::*;
    localparam int DEPTH = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic enq_valid = 0, iss_ready = 0, miss_start = 0, miss_long = 0, miss_done = 0;
    logic [SEQ_W-1:0]  enq_seq = '0, iss_seq, refetch_seq, nseq;
    logic [DATA_W-1:0] enq_data = '0, iss_data;
    logic enq_ready, iss_valid, refetch_valid;
    logic [CNT_W-1:0] occ_count;

    int checks = 0, fails = 0;
    bit done = 0;
    int exp_q[$];
    bit m_pend = 0, rf_due = 0, rf_next = 0, sq_any = 0, after_trig = 0;
    int sq_seq = 0, rf_seq = 0;

    iq_squash_ctrl #(.DEPTH(DEPTH)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] pay(input logic [SEQ_W-1:0] s);
        return DATA_W'({s, ~s});
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // front end: next sequence number advances on each accepted entry
    always @(posedge clk) begin
        if (rst) nseq <= '0;
        else if (enq_valid && enq_ready) nseq <= nseq + 1'b1;
    end

    // monitor and scoreboard, evaluated mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            bit trig, e_iss, e_rdy;
            string t_occ;
            trig  = !m_pend && miss_start && miss_long;
            e_iss = exp_q.size() > 0 && !trig;
            e_rdy = !m_pend && !trig && exp_q.size() < DEPTH;
            t_occ = after_trig ? "R4" : ((miss_start && !miss_long) ? "R5" : "R10");
            check(occ_count == exp_q.size(), t_occ, occ_count, exp_q.size());
            check(iss_valid == e_iss, trig ? "R9" : "R2", iss_valid, e_iss);
            if (e_iss && iss_valid) begin
                check(iss_seq == exp_q[0], "R2", iss_seq, exp_q[0]);
                check(iss_data == pay(SEQ_W'(exp_q[0])), "R2", iss_data, pay(SEQ_W'(exp_q[0])));
            end
            check(enq_ready == e_rdy,
                  (m_pend || trig) ? "R6" : (exp_q.size() == DEPTH ? "R3" : "R2"),
                  enq_ready, e_rdy);
            check(refetch_valid == rf_due, "R7 R8", refetch_valid, rf_due);
            if (rf_due) check(refetch_seq == SEQ_W'(rf_seq), "R7", refetch_seq, rf_seq);
            rf_next = 0;
            after_trig = trig;
            if (trig) begin
                sq_any = exp_q.size() >= 2;
                if (sq_any) sq_seq = exp_q[1];
                while (exp_q.size() > 1) void'(exp_q.pop_back());
                m_pend = 1;
            end else begin
                if (m_pend && miss_done) begin
                    m_pend = 0;
                    rf_next = sq_any;
                    rf_seq = sq_seq;
                end
                if (e_iss && iss_ready) void'(exp_q.pop_front());
                if (enq_valid && e_rdy) exp_q.push_back(int'(enq_seq));
            end
            rf_due = rf_next;
        end
    end

    task automatic step(input bit ev, input bit ir, input bit ms, input bit ml,
                        input bit md, input int n);
        repeat (n) begin
            @(posedge clk); #1;
            enq_valid = ev; iss_ready = ir;
            miss_start = ms; miss_long = ml; miss_done = md;
            enq_seq = nseq; enq_data = pay(nseq);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(occ_count == 0, "R1", occ_count, 0);
        check(iss_valid == 0, "R1", iss_valid, 0);
        check(refetch_valid == 0, "R1", refetch_valid, 0);
        check(enq_ready == 1, "R1", enq_ready, 1);
        rst = 0;
        step(1, 0, 0, 0, 0, 11);   // fill past DEPTH: R3
        step(0, 1, 0, 0, 0, 3);    // drain three in order: R2
        step(1, 0, 1, 0, 0, 1);    // short miss ignored: R5
        step(0, 0, 0, 0, 0, 1);
        step(1, 0, 1, 1, 0, 1);    // long miss squashes: R4 R9
        step(1, 0, 0, 0, 0, 3);    // enqueue held off: R6
        step(1, 0, 1, 1, 0, 1);    // second miss merged: R8
        step(1, 1, 0, 0, 0, 2);
        step(1, 0, 1, 1, 1, 1);    // done plus start while pending: R7 R8
        step(1, 0, 0, 0, 0, 3);
        step(0, 0, 0, 0, 1, 1);    // done with nothing pending: R7
        step(1, 1, 0, 0, 0, 6);    // normal flow resumes: R2
        step(0, 1, 0, 0, 0, 10);   // drain
        step(1, 0, 0, 0, 0, 1);    // one entry
        step(0, 0, 1, 1, 0, 1);    // miss with single entry: no refetch R7
        step(0, 0, 0, 0, 0, 2);
        step(0, 0, 0, 0, 1, 1);
        step(0, 1, 0, 0, 0, 3);
        step(0, 0, 1, 1, 0, 1);    // miss on empty queue
        step(0, 0, 0, 0, 1, 1);
        step(1, 1, 0, 0, 0, 4);
        step(0, 0, 0, 0, 0, 3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule